// File: doc/BRIEF.md
# Program Counter Return Stack

This block keeps the instruction address of a small 4-bit processor and the addresses its subroutines return to. It holds four 12-bit levels as a ring, and a level pointer picks which one is the live program counter. The other three levels hold pending return addresses. Entering a subroutine moves the pointer forward. Leaving one moves it back. The address that was saved before the call then becomes the program counter again, and no copying between registers is needed.

The sequencer of the processor drives one request per instruction: step the address, jump, call or return. The block shows the live address and the pointer value, which serves as a nesting depth for test. The pointer wraps with no error. A fourth nested call therefore overwrites the oldest saved address, and a return at depth 0 selects level 3. When several requests arrive in one cycle, a fixed priority decides: call, then return, then jump, then increment.

Top module: `pc_ring_stack`

## Requirements
- R1: While reset is low, and after it is released, the program counter reads 0x000 and depth reads 0. Every level holds 0x000, so four returns made straight after reset each read 0x000, with depth going 3, 2, 1, 0.
- R2: An increment request with no other request adds one to the program counter modulo 4096, so 0xFFF goes to 0x000. Depth does not change.
- R3: A jump request with no call or return loads the jump address into the program counter and leaves depth unchanged.
- R4: A call request sets depth to (depth+1) mod 4 and makes the call target the program counter.
- R5: A return request with no call sets depth to (depth-1) mod 4 and makes the program counter the value the call stored: the program counter at that call plus one.
- R6: Three nested calls followed by three returns give back each saved address in reverse order. The address after the third return is the one that was live before the first call, plus one.
- R7: A fourth nested call wraps depth from 3 to 0 and overwrites the oldest level, with no error. The four returns that follow read the three most recent saved addresses and then the fourth call's target plus its own increments (the overwritten level).
- R8: When call and return are requested in the same cycle, only the call takes effect.
- R9: A return outranks jump and increment, and a jump outranks increment. Only the winning request changes the program counter or depth.
- R10: With no request, the program counter and depth keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| inc_en | input | 1 | Step the program counter by one |
| call_req | input | 1 | Enter a subroutine |
| call_tgt | input | 12 | Subroutine start address |
| ret_req | input | 1 | Leave a subroutine |
| jmp_req | input | 1 | Load a new address into the live level |
| jmp_tgt | input | 12 | Jump address |
| pc_out | output | 12 | Live program counter |
| depth_out | output | 2 | Level pointer, which is the nesting depth |

## Verification
Every request updates registers on the rising edge where it is present. Its effect on `pc_out` and `depth_out` is due on that same edge, one cycle after the request is driven. The reset value appears at once while reset is low. The bench drives each request on a falling edge and queues the expected pair. The monitor then compares it one time unit after the next rising edge, so each check samples exactly the cycle in which the result settles and never the edge itself. Chains of calls and returns are checked cycle by cycle, so a value saved at a wrong level shows up in the return cycle that should have read it back.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Operation chosen for the current cycle after priority resolution.
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_JMP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } pcs_op_e;

endpackage

// File: rtl/pcs_op_arbiter.sv
module pcs_op_arbiter
  import pcs_pkg::*;
(
  input  logic    inc_en,
  input  logic    call_req,
  input  logic    ret_req,
  input  logic    jmp_req,
  output pcs_op_e op
);

  // Fixed priority: call > return > jump > increment.
  always_comb begin
    if (call_req)     op = OP_CALL;
    else if (ret_req) op = OP_RET;
    else if (jmp_req) op = OP_JMP;
    else if (inc_en)  op = OP_INC;
    else              op = OP_HOLD;
  end

endmodule

// File: rtl/pcs_level_ptr.sv
module pcs_level_ptr
  import pcs_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int PTR_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pcs_op_e          op,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [PTR_W-1:0] nxt_ptr
);

  localparam logic [PTR_W-1:0] TOP_LVL = PTR_W'(LEVELS - 1);

  logic             ptr_en;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] ptr_q;

  // Forward neighbour (used by call) with ring wrap.
  always_comb begin
    nxt_ptr = (ptr_q == TOP_LVL) ? '0 : ptr_q + 1'b1;
  end

  // Next-state selection and clock enable.
  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    case (op)
      OP_CALL: begin
        ptr_en = 1'b1;
        ptr_d  = nxt_ptr;
      end
      OP_RET: begin
        ptr_en = 1'b1;
        ptr_d  = (ptr_q == '0) ? TOP_LVL : ptr_q - 1'b1;
      end
      default: begin
        ptr_en = 1'b0;
        ptr_d  = ptr_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign cur_ptr = ptr_q;

  // R10
  ptr_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((op == OP_CALL) || (op == OP_RET)) |=> $stable(cur_ptr));

endmodule

// File: rtl/pcs_level_bank.sv
module pcs_level_bank
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEVELS = 4,
  localparam int PTR_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pcs_op_e           op,
  input  logic [PTR_W-1:0]  cur_ptr,
  input  logic [PTR_W-1:0]  nxt_ptr,
  input  logic [ADDR_W-1:0] call_tgt,
  input  logic [ADDR_W-1:0] jmp_tgt,
  output logic [ADDR_W-1:0] active_addr
);

  logic [ADDR_W-1:0] lvl_q  [LEVELS];
  logic [ADDR_W-1:0] lvl_d  [LEVELS];
  logic [LEVELS-1:0] lvl_we;
  logic [ADDR_W-1:0] step_addr;

  assign active_addr = lvl_q[cur_ptr];
  assign step_addr   = active_addr + ADDR_W'(1);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic is_cur;
    logic is_nxt;

    assign is_cur = (cur_ptr == PTR_W'(g));
    assign is_nxt = (nxt_ptr == PTR_W'(g));

    // Next-state for one level.
    always_comb begin
      lvl_we[g] = 1'b0;
      lvl_d[g]  = lvl_q[g];
      case (op)
        OP_INC: if (is_cur) begin
          lvl_we[g] = 1'b1;
          lvl_d[g]  = step_addr;
        end
        OP_JMP: if (is_cur) begin
          lvl_we[g] = 1'b1;
          lvl_d[g]  = jmp_tgt;
        end
        OP_CALL: begin
          if (is_cur) begin
            lvl_we[g] = 1'b1;
            lvl_d[g]  = step_addr;
          end else if (is_nxt) begin
            lvl_we[g] = 1'b1;
            lvl_d[g]  = call_tgt;
          end
        end
        default: begin
          lvl_we[g] = 1'b0;
          lvl_d[g]  = lvl_q[g];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lvl_q[g] <= '0;
      else if (lvl_we[g]) lvl_q[g] <= lvl_d[g];
    end

    // R5
    ret_keeps_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RET) |=> $stable(lvl_q[g]));
  end

  // R4
  call_two_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CALL) |-> ($countones(lvl_we) == 2));

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_CALL) |-> $onehot0(lvl_we));

endmodule

// File: rtl/pc_ring_stack.sv
module pc_ring_stack
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEVELS = 4,
  localparam int PTR_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              call_req,
  input  logic [ADDR_W-1:0] call_tgt,
  input  logic              ret_req,
  input  logic              jmp_req,
  input  logic [ADDR_W-1:0] jmp_tgt,
  output logic [ADDR_W-1:0] pc_out,
  output logic [PTR_W-1:0]  depth_out
);

  pcs_op_e          op;
  logic [PTR_W-1:0] cur_ptr;
  logic [PTR_W-1:0] nxt_ptr;

  pcs_op_arbiter u_arb (
    .inc_en   (inc_en),
    .call_req (call_req),
    .ret_req  (ret_req),
    .jmp_req  (jmp_req),
    .op       (op)
  );

  pcs_level_ptr #(.LEVELS(LEVELS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .cur_ptr (cur_ptr),
    .nxt_ptr (nxt_ptr)
  );

  pcs_level_bank #(.ADDR_W(ADDR_W), .LEVELS(LEVELS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .cur_ptr     (cur_ptr),
    .nxt_ptr     (nxt_ptr),
    .call_tgt    (call_tgt),
    .jmp_tgt     (jmp_tgt),
    .active_addr (pc_out)
  );

  assign depth_out = cur_ptr;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !call_req && !ret_req && !jmp_req) |=>
      ((pc_out == $past(pc_out) + ADDR_W'(1)) && $stable(depth_out)));

  // R3
  jmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_req && !call_req && !ret_req) |=>
      ((pc_out == $past(jmp_tgt)) && $stable(depth_out)));

  // R4
  call_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> ((pc_out == $past(call_tgt)) &&
      (depth_out == (($past(depth_out) == PTR_W'(LEVELS - 1)) ? '0 : $past(depth_out) + 1'b1))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_en || call_req || ret_req || jmp_req) |=>
      ($stable(pc_out) && $stable(depth_out)));

endmodule

// File: tb/pc_ring_stack_bench.sv
module pc_ring_stack_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        inc_en;
  logic        call_req;
  logic [11:0] call_tgt;
  logic        ret_req;
  logic        jmp_req;
  logic [11:0] jmp_tgt;
  logic [11:0] pc_out;
  logic [1:0]  depth_out;

  typedef struct {
    logic [11:0] pc;
    logic [1:0]  dep;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks;
  int          n_errors;
  bit          finished;

  // Reference state built from the requirements.
  logic [11:0] m_lvl [4];
  logic [1:0]  m_ptr;

  pc_ring_stack u_pc_ring_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_en    (inc_en),
    .call_req  (call_req),
    .call_tgt  (call_tgt),
    .ret_req   (ret_req),
    .jmp_req   (jmp_req),
    .jmp_tgt   (jmp_tgt),
    .pc_out    (pc_out),
    .depth_out (depth_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic compare(input logic [11:0] pc_e, input logic [1:0] dep_e, input string tag);
    n_checks++;
    if (pc_out !== pc_e || depth_out !== dep_e) begin
      n_errors++;
      $display("FAIL %s: actual pc=%h depth=%0d, expected pc=%h depth=%0d",
               tag, pc_out, depth_out, pc_e, dep_e);
    end
  endtask

  // Driver: apply one request set, update the reference, queue the expectation.
  task automatic step(input bit inc, input bit call, input logic [11:0] ct,
                      input bit ret, input bit jmp, input logic [11:0] jt,
                      input string tag);
    exp_t e;
    @(negedge clk);
    inc_en   = inc;
    call_req = call;
    call_tgt = ct;
    ret_req  = ret;
    jmp_req  = jmp;
    jmp_tgt  = jt;
    if (call) begin
      m_lvl[m_ptr] = m_lvl[m_ptr] + 12'd1;
      m_ptr        = m_ptr + 2'd1;
      m_lvl[m_ptr] = ct;
    end else if (ret) begin
      m_ptr = m_ptr - 2'd1;
    end else if (jmp) begin
      m_lvl[m_ptr] = jt;
    end else if (inc) begin
      m_lvl[m_ptr] = m_lvl[m_ptr] + 12'd1;
    end
    e.pc  = m_lvl[m_ptr];
    e.dep = m_ptr;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: one time unit after each rising edge, check the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        compare(e.pc, e.dep, e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    inc_en   = 1'b0;
    call_req = 1'b0;
    call_tgt = '0;
    ret_req  = 1'b0;
    jmp_req  = 1'b0;
    jmp_tgt  = '0;
    for (int i = 0; i < 4; i++) m_lvl[i] = '0;
    m_ptr = '0;

    repeat (3) @(negedge clk);
    compare(12'h000, 2'd0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(12'h000, 2'd0, "R1 after release");

    // R1: every level cleared; returns walk 3,2,1,0 reading zero.
    for (int i = 0; i < 4; i++) step(0, 0, '0, 1, 0, '0, "R1 level zero via return");

    // R10: idle holds.
    step(0, 0, '0, 0, 0, '0, "R10 idle");
    // R2: increments and wrap.
    step(1, 0, '0, 0, 0, '0, "R2 inc");
    step(1, 0, '0, 0, 0, '0, "R2 inc");
    step(0, 0, '0, 0, 1, 12'hFFE, "R3 jump");
    step(1, 0, '0, 0, 0, '0, "R2 inc to FFF");
    step(1, 0, '0, 0, 0, '0, "R2 wrap to 000");
    step(0, 0, '0, 0, 1, 12'h100, "R3 jump 100");
    step(0, 0, '0, 0, 0, '0, "R10 idle after jump");

    // R4/R5/R6: three nested calls and returns.
    step(0, 1, 12'h200, 0, 0, '0, "R4 call 1");
    step(1, 0, '0, 0, 0, '0, "R2 inc in sub");
    step(0, 1, 12'h300, 0, 0, '0, "R4 call 2");
    step(0, 1, 12'h400, 0, 0, '0, "R4 call 3");
    step(1, 0, '0, 0, 0, '0, "R2 inc at depth 3");
    step(0, 0, '0, 1, 0, '0, "R5 return 3");
    step(0, 0, '0, 1, 0, '0, "R6 return 2");
    step(0, 0, '0, 1, 0, '0, "R6 return 1 to 101");

    // R7: four nested calls wrap and overwrite.
    step(0, 1, 12'hA00, 0, 0, '0, "R7 call a");
    step(0, 1, 12'hB00, 0, 0, '0, "R7 call b");
    step(0, 1, 12'hC00, 0, 0, '0, "R7 call c");
    step(0, 1, 12'hD00, 0, 0, '0, "R7 call d wraps");
    step(1, 0, '0, 0, 0, '0, "R7 inc at wrapped level");
    for (int i = 0; i < 4; i++) step(0, 0, '0, 1, 0, '0, "R7 unwind");

    // R8: call beats return.
    step(0, 1, 12'h555, 1, 0, '0, "R8 call and return");
    step(1, 1, 12'h666, 1, 1, 12'h777, "R8 call beats all");
    // R9: return beats jump and increment; jump beats increment.
    step(1, 0, '0, 1, 1, 12'h123, "R9 return wins");
    step(1, 0, '0, 0, 1, 12'h321, "R9 jump wins");
    step(1, 0, '0, 1, 0, '0, "R9 return over inc");
    step(0, 0, '0, 0, 0, '0, "R10 idle hold");
    step(0, 0, '0, 0, 0, '0, "R10 idle hold again");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule